// File: doc/BRIEF.md
# Bit-Synchronous Frame Receiver with Per-Frame Status

This block receives a serial, bit-stuffed frame stream, one bit per cycle in which the bit strobe is high. It hunts for the `01111110` delimiter and removes inserted zero bits. It assembles the remaining bits into octets, least significant bit first. The octets go out on a byte port, and the frame check sequence octets go out with them.

Each delimiter closes the current frame and opens the next. When a frame closes, the block issues a single status word. The word holds the octet count and a set of error flags gathered while the frame was received.

Two settings come from outside the block. A length limit caps how many octets reach the byte port. A mode input picks the 16-bit or the 32-bit check sequence. A carrier-present input and a missing-transition input from the clock-recovery logic feed two of the status flags. A ready input from the consumer feeds the overrun flag.

Top module: `hdlc_rx_status`

## Requirements
- R1: A frame lies between two `01111110` delimiters, and one delimiter may both close one frame and open the next. Delimiters with no frame bit between them produce no status word.
- R2: Inside a frame, a 0 that follows five consecutive 1 bits is removed and is not part of the data.
- R3: Frame bits form octets least significant bit first. Each octet that is stored appears on `byte_data`, with `byte_vld` high for one cycle, the cycle after the strobe of the bit that completed it. This includes the 2 or 4 check-sequence octets.
- R4: The cycle after the strobe of a closing delimiter's last bit, `stat_vld` is high for one cycle. `stat_len` then holds the number of whole octets received between the delimiters, check-sequence octets included. `stat_err` bits are: 0 abort, 1 misaligned, 2 length, 3 check, 4 overrun, 5 carrier, 6 transition.
- R5: With `crc32_sel` low, the check uses polynomial 0x1021, LSB first, preset 0xFFFF, and a good frame leaves 0xF0B8. With it high, it uses the 32-bit polynomial 0x04C11DB7, preset all ones, and a good frame leaves 0xDEBB20E3. On an octet-aligned, unaborted frame, a wrong residue sets bit 3.
- R6: Octets beyond the first `max_len` of a frame are not put on the byte port. `stat_len` still counts them. Bit 2 is set at the close when `stat_len` exceeds `max_len`.
- R7: A frame whose bit count is not a multiple of eight sets bit 1. `stat_len` reports the whole octets, and bit 3 is not reported.
- R8: Seven consecutive 1 bits inside a frame abort it. Bits are then ignored until the next delimiter. That delimiter issues a status word with bit 0 set, and bits 1 and 3 clear, if at least one frame bit preceded the abort. Otherwise it issues none.
- R9: If an octet to be stored completes while `byte_ready` is low, that octet is dropped and bit 4 is set.
- R10: `carrier_ok` low in any cycle while a frame is open sets bit 5.
- R11: `dpll_err` high in any cycle while a frame is open sets bit 6.
- R12: After reset, `byte_vld` and `stat_vld` are low, and bits before the first delimiter are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Line bit strobe |
| bit_in | input | 1 | Line bit |
| carrier_ok | input | 1 | Carrier present |
| dpll_err | input | 1 | Missing-transition indication from clock recovery |
| crc32_sel | input | 1 | 1 selects the 32-bit check sequence |
| max_len | input | LEN_W | Octets stored per frame |
| byte_ready | input | 1 | Consumer can take an octet |
| byte_vld | output | 1 | Octet valid |
| byte_data | output | 8 | Received octet |
| stat_vld | output | 1 | Frame status valid |
| stat_len | output | LEN_W | Octets received in the frame |
| stat_err | output | 7 | Frame error flags |

## Verification
A fault in the ones counter or the delay line corrupts the next octet that the block emits. It also shifts or suppresses the following status word, so the error shows within one frame. A residue register that is stale or preset wrongly sets the check flag on a good frame at its very next close. A sticky error flag that is never cleared shows up as a spurious bit in the next clean frame's status word. The bench therefore runs clean frames directly after every error case.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  // receiver frame state
  typedef enum logic [1:0] {
    RX_HUNT = 2'd0,
    RX_OPEN = 2'd1,
    RX_DROP = 2'd2
  } rx_state_e;

  // status flags; abort sits in bit 0, transition error in bit 6
  typedef struct packed {
    logic dpll;
    logic car;
    logic ovr;
    logic chk;
    logic lenv;
    logic align;
    logic abort;
  } rx_err_t;

  localparam int ERR_W = 7;

  // reflected polynomials and good residues
  localparam logic [15:0] FCS16_POLY = 16'h8408;
  localparam logic [15:0] FCS16_GOOD = 16'hF0B8;
  localparam logic [31:0] FCS32_POLY = 32'hEDB88320;
  localparam logic [31:0] FCS32_GOOD = 32'hDEBB20E3;

endpackage

// File: rtl/hdlc_line_decode.sv
module hdlc_line_decode #(
  parameter int FLAG_ONES  = 6,
  parameter int STUFF_ONES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic flag_hit,
  output logic abort_hit,
  output logic data_push
);

  localparam int CW = $clog2(FLAG_ONES + 2);
  localparam logic [CW-1:0] ONES_MAX = CW'(FLAG_ONES + 1);

  logic [CW-1:0] ones_q, ones_d;
  logic          stuff_hit;
  logic          ones_run_end;
  logic          ones_long;

  assign ones_run_end = (ones_q == CW'(FLAG_ONES));
  assign ones_long    = (ones_q > CW'(FLAG_ONES));
  assign flag_hit     = bit_vld && !bit_in && ones_run_end;
  assign abort_hit    = bit_vld &&  bit_in && ones_run_end;
  assign stuff_hit    = bit_vld && !bit_in && (ones_q == CW'(STUFF_ONES));
  assign data_push    = bit_vld && !flag_hit && !abort_hit && !stuff_hit && !ones_long;

  always_comb begin
    ones_d = ones_q;
    if (bit_vld) begin
      if (!bit_in)                ones_d = '0;
      else if (ones_q != ONES_MAX) ones_d = ones_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_d;
  end

endmodule

// File: rtl/hdlc_bit_delay.sv
module hdlc_bit_delay #(
  parameter int DEPTH = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic push,
  input  logic din,
  output logic dout_vld,
  output logic dout
);

  localparam int FW = $clog2(DEPTH + 1);
  localparam logic [FW-1:0] FULL = FW'(DEPTH);

  logic [DEPTH-1:0] sr_q, sr_d;
  logic [FW-1:0]    fill_q, fill_d;

  assign sr_d[0] = push ? din : sr_q[0];
  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    assign sr_d[g] = push ? sr_q[g-1] : sr_q[g];
  end

  always_comb begin
    fill_d = fill_q;
    if (clr)                        fill_d = '0;
    else if (push && fill_q != FULL) fill_d = fill_q + FW'(1);
  end

  assign dout_vld = push && (fill_q == FULL);
  assign dout     = sr_q[DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      fill_q <= '0;
    end else begin
      sr_q   <= sr_d;
      fill_q <= fill_d;
    end
  end

endmodule

// File: rtl/hdlc_fcs_check.sv
module hdlc_fcs_check
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic step,
  input  logic din,
  input  logic wide,
  output logic good
);

  logic [31:0] crc_q, crc_d;
  logic [15:0] nxt16;
  logic [31:0] nxt32;
  logic        fb;

  assign fb    = crc_q[0] ^ din;
  assign nxt16 = {1'b0, crc_q[15:1]} ^ (fb ? FCS16_POLY : 16'h0000);
  assign nxt32 = {1'b0, crc_q[31:1]} ^ (fb ? FCS32_POLY : 32'h0000_0000);

  always_comb begin
    crc_d = crc_q;
    if (init)      crc_d = '1;
    else if (step) crc_d = wide ? nxt32 : {16'h0000, nxt16};
  end

  assign good = wide ? (crc_q == FCS32_GOOD) : (crc_q[15:0] == FCS16_GOOD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else        crc_q <= crc_d;
  end

endmodule

// File: rtl/hdlc_rx_status.sv
module hdlc_rx_status
  import hdlc_rx_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             carrier_ok,
  input  logic             dpll_err,
  input  logic             crc32_sel,
  input  logic [LEN_W-1:0] max_len,
  input  logic             byte_ready,
  output logic             byte_vld,
  output logic [7:0]       byte_data,
  output logic             stat_vld,
  output logic [LEN_W-1:0] stat_len,
  output logic [ERR_W-1:0] stat_err
);

  localparam int FLAG_ONES = 6;
  localparam int DLY_DEPTH = FLAG_ONES + 1;  // delimiter bits pushed before it is recognised

  // reset: asserted asynchronously, released on the clock
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic flag_hit, abort_hit, data_push;
  logic dl_vld, dl_bit, fcs_good;

  rx_state_e        state_q, state_d;
  logic [7:0]       asm_q, asm_d, asm_nx;
  logic [2:0]       bpos_q, bpos_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d;
  logic             ovr_q, ovr_d, car_q, car_d, dpl_q, dpl_d;
  logic             bv_q, bv_d;
  logic [7:0]       bd_q, bd_d;
  logic             sv_q, sv_d;
  logic [LEN_W-1:0] sl_q, sl_d;
  rx_err_t          se_q, se_d, err_now;

  logic in_open, take, octet_done, store_ok, emit, ovr_hit, closing, framed;

  hdlc_line_decode #(.FLAG_ONES(FLAG_ONES), .STUFF_ONES(FLAG_ONES - 1)) u_dec (
    .clk       (clk),
    .rst_n     (rst_s_q),
    .bit_vld   (bit_vld),
    .bit_in    (bit_in),
    .flag_hit  (flag_hit),
    .abort_hit (abort_hit),
    .data_push (data_push)
  );

  hdlc_bit_delay #(.DEPTH(DLY_DEPTH)) u_dly (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .clr      (flag_hit || abort_hit),
    .push     (data_push && in_open),
    .din      (bit_in),
    .dout_vld (dl_vld),
    .dout     (dl_bit)
  );

  hdlc_fcs_check u_fcs (
    .clk   (clk),
    .rst_n (rst_s_q),
    .init  (flag_hit),
    .step  (take),
    .din   (dl_bit),
    .wide  (crc32_sel),
    .good  (fcs_good)
  );

  // datapath decode
  assign in_open    = (state_q == RX_OPEN);
  assign framed     = (state_q != RX_HUNT);
  assign take       = in_open && dl_vld;
  assign asm_nx     = {dl_bit, asm_q[7:1]};
  assign octet_done = take && (bpos_q == 3'd7);
  assign store_ok   = (cnt_q < max_len);
  assign emit       = octet_done && store_ok && byte_ready;
  assign ovr_hit    = octet_done && store_ok && !byte_ready;
  assign closing    = flag_hit && framed && seen_q;

  always_comb begin
    err_now       = '0;
    err_now.abort = (state_q == RX_DROP);
    err_now.align = !err_now.abort && (bpos_q != 3'd0);
    err_now.chk   = !err_now.abort && (bpos_q == 3'd0) && !fcs_good;
    err_now.lenv  = (cnt_q > max_len);
    err_now.ovr   = ovr_q;
    err_now.car   = car_q;
    err_now.dpll  = dpl_q;
  end

  // next-state
  always_comb begin
    state_d = state_q;
    if (flag_hit)                  state_d = RX_OPEN;
    else if (abort_hit && in_open) state_d = RX_DROP;

    seen_d = seen_q;
    bpos_d = bpos_q;
    asm_d  = asm_q;
    cnt_d  = cnt_q;
    if (flag_hit) begin
      seen_d = 1'b0;
      bpos_d = 3'd0;
      cnt_d  = '0;
    end else if (take) begin
      seen_d = 1'b1;
      bpos_d = bpos_q + 3'd1;
      asm_d  = asm_nx;
      if (octet_done && !(&cnt_q)) cnt_d = cnt_q + LEN_W'(1);
    end

    ovr_d = ovr_q;
    car_d = car_q;
    dpl_d = dpl_q;
    if (flag_hit) begin
      ovr_d = 1'b0;
      car_d = 1'b0;
      dpl_d = 1'b0;
    end else begin
      if (ovr_hit)              ovr_d = 1'b1;
      if (framed && !carrier_ok) car_d = 1'b1;
      if (framed && dpll_err)    dpl_d = 1'b1;
    end

    bv_d = emit;
    bd_d = emit ? asm_nx : bd_q;
    sv_d = closing;
    sl_d = closing ? cnt_q : sl_q;
    se_d = closing ? err_now : se_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      state_q <= RX_HUNT;
      asm_q   <= '0;
      bpos_q  <= '0;
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      ovr_q   <= 1'b0;
      car_q   <= 1'b0;
      dpl_q   <= 1'b0;
      bv_q    <= 1'b0;
      bd_q    <= '0;
      sv_q    <= 1'b0;
      sl_q    <= '0;
      se_q    <= '0;
    end else begin
      state_q <= state_d;
      asm_q   <= asm_d;
      bpos_q  <= bpos_d;
      cnt_q   <= cnt_d;
      seen_q  <= seen_d;
      ovr_q   <= ovr_d;
      car_q   <= car_d;
      dpl_q   <= dpl_d;
      bv_q    <= bv_d;
      bd_q    <= bd_d;
      sv_q    <= sv_d;
      sl_q    <= sl_d;
      se_q    <= se_d;
    end
  end

  assign byte_vld  = bv_q;
  assign byte_data = bd_q;
  assign stat_vld  = sv_q;
  assign stat_len  = sl_q;
  assign stat_err  = se_q;

endmodule

// File: rtl/hdlc_rx_status_chk.sv
module hdlc_rx_status_chk
  import hdlc_rx_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_vld,
  input logic             bit_in,
  input logic [LEN_W-1:0] max_len,
  input logic             byte_ready,
  input logic             byte_vld,
  input logic             stat_vld,
  input logic [LEN_W-1:0] stat_len,
  input logic [ERR_W-1:0] stat_err
);

  rx_err_t e;
  assign e = rx_err_t'(stat_err);

  // octets put out since the last status word
  logic [LEN_W:0] nbytes_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        nbytes_q <= '0;
    else if (stat_vld) nbytes_q <= '0;
    else if (byte_vld) nbytes_q <= nbytes_q + (LEN_W+1)'(1);
  end

  p_byte_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(bit_vld));

  p_status_after_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld |-> $past(bit_vld && !bit_in));

  p_status_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld |=> !stat_vld);

  p_byte_not_with_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld && stat_vld));

  p_len_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld |-> (e.lenv == (stat_len > max_len)));

  p_truncate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (nbytes_q < {1'b0, max_len}));

  p_abort_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld && e.abort) |-> (!e.align && !e.chk));

  p_align_masks_check_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld && e.align) |-> !e.chk);

  p_byte_needs_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(byte_ready));

endmodule

bind hdlc_rx_status hdlc_rx_status_chk #(.LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_vld    (bit_vld),
  .bit_in     (bit_in),
  .max_len    (max_len),
  .byte_ready (byte_ready),
  .byte_vld   (byte_vld),
  .stat_vld   (stat_vld),
  .stat_len   (stat_len),
  .stat_err   (stat_err)
);

// File: tb/hdlc_rx_status_test.sv
`timescale 1ns/1ps
module hdlc_rx_status_test;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             bit_vld = 1'b0, bit_in = 1'b0;
  logic             carrier_ok = 1'b1, dpll_err = 1'b0, crc32_sel = 1'b0;
  logic [LEN_W-1:0] max_len = 8'd32;
  logic             byte_ready = 1'b1;
  logic             byte_vld, stat_vld;
  logic [7:0]       byte_data;
  logic [LEN_W-1:0] stat_len;
  logic [6:0]       stat_err;

  hdlc_rx_status #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .carrier_ok(carrier_ok), .dpll_err(dpll_err), .crc32_sel(crc32_sel),
    .max_len(max_len), .byte_ready(byte_ready), .byte_vld(byte_vld),
    .byte_data(byte_data), .stat_vld(stat_vld), .stat_len(stat_len),
    .stat_err(stat_err)
  );

  int checks = 0, errors = 0;
  logic [7:0] got [64];
  int nb = 0, st_cnt = 0;
  logic [LEN_W-1:0] st_len = '0;
  logic [6:0] st_err = '0;
  logic [7:0] frm [64];
  int flen = 0, ones = 0, salt = 0;
  bit k_ovr = 0, k_car = 0, k_dpll = 0;

  // vector: {wide, payload, pattern, corrupt, max_len, exp_len, exp_err}
  localparam logic [31:0] VEC [9] = '{
    {1'b0, 5'd3, 2'd0, 1'b0, 8'd32, 8'd5,  7'h00},
    {1'b1, 5'd3, 2'd0, 1'b0, 8'd32, 8'd7,  7'h00},
    {1'b0, 5'd6, 2'd0, 1'b1, 8'd32, 8'd8,  7'h08},
    {1'b1, 5'd5, 2'd0, 1'b1, 8'd32, 8'd9,  7'h08},
    {1'b0, 5'd6, 2'd0, 1'b0, 8'd4,  8'd8,  7'h04},
    {1'b1, 5'd8, 2'd0, 1'b0, 8'd12, 8'd12, 7'h00},
    {1'b0, 5'd6, 2'd1, 1'b0, 8'd32, 8'd8,  7'h00},
    {1'b1, 5'd0, 2'd0, 1'b0, 8'd32, 8'd4,  7'h00},
    {1'b0, 5'd4, 2'd0, 1'b1, 8'd3,  8'd6,  7'h0C}
  };

  always @(negedge clk) begin
    if (byte_vld) begin
      if (nb < 64) got[nb] = byte_data;
      nb++;
    end
    if (stat_vld) begin
      st_len = stat_len;
      st_err = stat_err;
      st_cnt++;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_in = b; bit_vld = 1'b1;
    @(negedge clk); bit_vld = 1'b0;
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) send_bit(i != 0 && i != 7);
    ones = 0;
  endtask

  task automatic send_dbit(input logic b);
    send_bit(b);
    if (b) ones++; else ones = 0;
    if (ones == 5) begin send_bit(1'b0); ones = 0; end
  endtask

  task automatic send_dbyte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_dbit(v[i]);
  endtask

  function automatic logic [31:0] fcs_upd(input logic [31:0] c, input logic [7:0] v, input bit w);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = r[0] ^ v[i];
      if (w) r = (r >> 1) ^ (fb ? 32'hEDB88320 : 32'h0);
      else   r = {16'h0, (r[15:0] >> 1) ^ (fb ? 16'h8408 : 16'h0)};
    end
    return r;
  endfunction

  task automatic build(input bit w, input int npay, input int pat, input bit cor);
    logic [31:0] c, f;
    c = '1;
    for (int k = 0; k < npay; k++) begin
      frm[k] = (pat == 1) ? (k[0] ? 8'h7E : 8'hFF) : 8'(k * 29 + salt * 7 + 3);
      c = fcs_upd(c, frm[k], w);
    end
    f = ~c;
    for (int j = 0; j < (w ? 4 : 2); j++) frm[npay + j] = f[8*j +: 8];
    flen = npay + (w ? 4 : 2);
    if (cor) frm[0] = frm[0] ^ 8'h01;
  endtask

  task automatic run_frame(input bit w, input int npay, input int pat, input bit cor,
                           input int maxl, input int elen, input int eerr, input string tag);
    int s0, enb, mism;
    crc32_sel = w;
    max_len = LEN_W'(maxl);
    build(w, npay, pat, cor);
    s0 = st_cnt;
    nb = 0;
    byte_ready = !k_ovr;
    send_flag();
    for (int k = 0; k < flen; k++) begin
      if (k == 1 && k_car) begin @(negedge clk) carrier_ok = 1'b0; @(negedge clk) carrier_ok = 1'b1; end
      if (k == 1 && k_dpll) begin @(negedge clk) dpll_err = 1'b1; @(negedge clk) dpll_err = 1'b0; end
      send_dbyte(frm[k]);
    end
    send_flag();
    repeat (3) @(negedge clk);
    byte_ready = 1'b1;
    enb = k_ovr ? 0 : ((elen < maxl) ? elen : maxl);
    chk(st_cnt == s0 + 1, {tag, " R4 one status word"}, st_cnt - s0, 1);
    chk(int'(st_len) == elen, {tag, " R4 length"}, int'(st_len), elen);
    chk(int'(st_err) == eerr, {tag, " R4 flags"}, int'(st_err), eerr);
    chk(nb == enb, {tag, " R6 octets put out"}, nb, enb);
    mism = 0;
    for (int i = 0; i < enb && i < nb; i++) if (got[i] != frm[i]) mism++;
    chk(mism == 0, {tag, " R3 octet content"}, mism, 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int s0;
    // R12 reset state
    repeat (5) @(negedge clk);
    chk(byte_vld == 1'b0, "R12 byte_vld in reset", int'(byte_vld), 0);
    chk(stat_vld == 1'b0, "R12 stat_vld in reset", int'(stat_vld), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(byte_vld == 1'b0 && stat_vld == 1'b0, "R12 outputs idle after reset",
        int'({byte_vld, stat_vld}), 0);

    // R12 bits ahead of the first delimiter are ignored
    s0 = st_cnt;
    foreach (VEC[i]) if (i < 4) send_bit(i[0]);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    repeat (3) @(negedge clk);
    chk(st_cnt == s0 && nb == 0, "R12 pre-delimiter bits ignored", st_cnt - s0 + nb, 0);

    // table of frames: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < 9; i++) begin
      logic [31:0] v;
      v = VEC[i];
      salt = i;
      run_frame(v[31], int'(v[30:26]), int'(v[25:24]), v[23], int'(v[22:15]),
                int'(v[14:7]), int'(v[6:0]), $sformatf("vec%0d R1 R2 R5", i));
    end

    // R1 back-to-back and shared-zero delimiters give no status
    s0 = st_cnt;
    send_flag(); send_flag(); send_flag();
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    repeat (3) @(negedge clk);
    chk(st_cnt == s0, "R1 empty delimiters", st_cnt - s0, 0);

    // R8 idle ones right after a delimiter give no status
    s0 = st_cnt;
    send_flag();
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    send_flag();
    repeat (3) @(negedge clk);
    chk(st_cnt == s0, "R8 abort without frame bits", st_cnt - s0, 0);

    // R8 abort inside a frame
    s0 = st_cnt;
    send_flag();
    send_dbyte(8'h12); send_dbyte(8'h34);
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    send_flag();
    repeat (3) @(negedge clk);
    chk(st_cnt == s0 + 1, "R8 aborted frame status", st_cnt - s0, 1);
    chk(st_err == 7'h01, "R8 abort flags", int'(st_err), 1);

    // R7 misaligned frame
    s0 = st_cnt;
    crc32_sel = 1'b0; max_len = 8'd32; nb = 0;
    send_flag();
    send_dbyte(8'h0F); send_dbyte(8'hA5); send_dbyte(8'h3C);
    send_dbit(1'b1); send_dbit(1'b0); send_dbit(1'b1);
    send_flag();
    repeat (3) @(negedge clk);
    chk(st_cnt == s0 + 1, "R7 status issued", st_cnt - s0, 1);
    chk(st_len == 8'd3, "R7 whole octets", int'(st_len), 3);
    chk(st_err == 7'h02, "R7 misaligned flag only", int'(st_err), 2);
    chk(nb == 3, "R7 octets put out", nb, 3);

    // R9 overrun
    k_ovr = 1; salt = 11;
    run_frame(1'b0, 3, 0, 1'b0, 32, 5, 7'h10, "R9 overrun");
    k_ovr = 0;

    // R10 carrier loss
    k_car = 1; salt = 12;
    run_frame(1'b1, 4, 0, 1'b0, 32, 8, 7'h20, "R10 carrier");
    k_car = 0;

    // R11 missing transition
    k_dpll = 1; salt = 13;
    run_frame(1'b0, 4, 0, 1'b0, 32, 6, 7'h40, "R11 transition");
    k_dpll = 0;

    // sticky flags cleared for the next frame
    salt = 14;
    run_frame(1'b0, 2, 0, 1'b0, 32, 4, 7'h00, "R4 clean after errors");

    finish_run();
  end

endmodule